// File: doc/BRIEF.md
# Ping-Pong IN Endpoint Buffer Controller

This block holds the transmit data of one USB device IN endpoint in two equal banks used alternately. Firmware owns one bank at a time. It pushes bytes into that bank through a valid/ready write stream, then hands the bank to the transmit side with a one-cycle commit pulse. The transmit side always sees the oldest committed bank as a packet descriptor (bank index and length) with a random-access byte read port. It frees that bank by completing a valid/ready handshake, which stands for the host's acknowledge. While the host drains one bank, firmware can fill the other.

Two flags on the firmware side report progress. The transmit-ready flag rises together with the firmware-ownership flag whenever the firmware bank is free; software clears the ready flag with an acknowledge pulse, and the interrupt output is that flag gated by an enable level. The firmware-ownership flag drops when a bank is committed and rises again one cycle later, or, if the next bank is still waiting to be sent, one cycle after the host frees it. A kill pulse withdraws the most recently committed bank that has not yet been handed over, for the case where a zero-length OUT packet aborts the data stage.

Back-pressure rules: on the write stream a byte is taken on any cycle where `wr_valid_i` and `wr_ready_o` are both high; `wr_ready_o` never depends on `wr_valid_i`. On the packet side `pkt_valid_o`, `pkt_bank_o` and `pkt_len_o` stay unchanged until `pkt_ready_i` is seen high with `pkt_valid_o`, the only other way to withdraw a packet being the kill pulse.

Top module: `iep_pingpong`

## Requirements
- R1: After reset both banks are free, bank 0 belongs to firmware, `txrdy_o` and `fifo_ctl_o` are 1, `byte_cnt_o` is 0 and `pkt_valid_o` is 0.
- R2: `irq_o` is high in exactly the cycles where `txrdy_o` is 1 and `irq_en_i` is 1.
- R3: A `txrdy_ack_i` pulse while `fifo_ctl_o` is 1 clears `txrdy_o` on the next cycle and leaves `fifo_ctl_o`, `byte_cnt_o` and the bank contents unchanged.
- R4: A write handshake stores `wr_data_i` at byte position `byte_cnt_o` of the firmware bank and raises `byte_cnt_o` by one on the next cycle.
- R5: `wr_ready_o` is 1 only when `fifo_ctl_o` is 1 and `byte_cnt_o` is below `EP_BYTES`; a `wr_valid_i` while it is 0 changes neither the count nor any stored byte.
- R6: A `commit_i` pulse while `fifo_ctl_o` is 1 (and `kill_i` is 0) queues the firmware bank for sending with its length, including a byte accepted in the same cycle (zero is allowed), and on the next cycle shows `fifo_ctl_o`, `txrdy_o` and `byte_cnt_o` at 0 with the other bank now the firmware bank; a commit while `fifo_ctl_o` is 0 does nothing.
- R7: While `fifo_ctl_o` is 0, `fifo_ctl_o` and `txrdy_o` both return to 1 (count 0) one cycle after the firmware bank is free: the cycle after a commit if that bank was already free, else the cycle after the host handshake that frees it.
- R8: `pkt_valid_o` is 1 whenever a bank is queued; `pkt_bank_o` (0 or 1) and `pkt_len_o` describe the oldest queued bank, `rd_data_o` returns its byte at `rd_addr_i`, and a handshake with `pkt_ready_i` frees that bank and moves to the next in commit order.
- R9: A `kill_i` pulse removes the most recently queued bank still queued after any same-cycle handshake; if firmware was waiting for a bank, the killed bank becomes the firmware bank; with nothing queued it has no effect; a commit in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Firmware byte offered |
| wr_data_i | input | DATA_W | Firmware byte |
| wr_ready_o | output | 1 | Firmware bank accepts bytes |
| txrdy_ack_i | input | 1 | Pulse: clear transmit-ready flag |
| commit_i | input | 1 | Pulse: hand firmware bank to transmit side |
| kill_i | input | 1 | Pulse: withdraw last queued bank |
| irq_en_i | input | 1 | Interrupt enable level |
| txrdy_o | output | 1 | Transmit-ready flag |
| fifo_ctl_o | output | 1 | Firmware owns a free bank |
| irq_o | output | 1 | Endpoint interrupt |
| byte_cnt_o | output | CW | Bytes in firmware bank |
| pkt_valid_o | output | 1 | A queued bank is offered |
| pkt_ready_i | input | 1 | Host acknowledge of offered bank |
| pkt_bank_o | output | 1 | Index of offered bank |
| pkt_len_o | output | CW | Length of offered bank |
| rd_addr_i | input | AW | Byte index into offered bank |
| rd_data_o | output | DATA_W | Byte of offered bank |

## Verification
The hardest state to reach is the one where both banks sit queued while firmware waits, because from there a kill must move the firmware side back onto the withdrawn bank, and a kill can also coincide with the host handshake that empties the queue. The stimulus holds `pkt_ready_i` low across two commits to stack both banks, then issues kill alone, kill together with a handshake, and kill together with a commit, before a long random phase with biased pulse rates keeps revisiting these collisions against a queue-based reference model.

// File: rtl/iep_pkg.sv
`timescale 1ns/1ps
package iep_pkg;
  // Ping-pong: exactly two banks, so bank indices are a single bit.
  localparam int unsigned IEP_BANKS = 2;
  typedef logic [0:0] bank_t;
  typedef logic [1:0] occ_t;

  function automatic bank_t other_bank(input bank_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/iep_ring.sv
`timescale 1ns/1ps
// Tracks which banks are queued for sending, oldest first, and which bank
// firmware works on.
module iep_ring
  import iep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ack_fire,
  input  logic  commit_fire,
  input  logic  kill_req,
  input  logic  fw_hold,
  output bank_t wp_o,
  output bank_t rp_o,
  output occ_t  occ_o,
  output logic  wp_busy_o
);
  bank_t wp_q, rp_q, wp_n, rp_n, rp_a;
  occ_t  occ_q, occ_n, occ_a;
  logic  kill_hit;

  always_comb begin
    rp_a  = rp_q;
    occ_a = occ_q;
    if (ack_fire) begin
      rp_a  = other_bank(rp_q);
      occ_a = occ_q - 2'd1;
    end
    kill_hit = kill_req && (occ_a != 2'd0);
    wp_n  = wp_q;
    rp_n  = rp_a;
    occ_n = occ_a;
    if (kill_hit) begin
      occ_n = occ_a - 2'd1;
      // Firmware waiting: the withdrawn bank sits just behind the write side.
      if (!fw_hold) wp_n = other_bank(wp_q);
      if (occ_n == 2'd0) rp_n = wp_n;
    end else if (commit_fire) begin
      occ_n = occ_a + 2'd1;
      wp_n  = other_bank(wp_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      occ_q <= occ_n;
    end
  end

  assign wp_o      = wp_q;
  assign rp_o      = rp_q;
  assign occ_o     = occ_q;
  assign wp_busy_o = (occ_q == 2'd2) || ((occ_q == 2'd1) && (rp_q == wp_q));
endmodule

// File: rtl/iep_fw_side.sv
`timescale 1ns/1ps
// Firmware-facing flags and byte counter.
module iep_fw_side #(
  parameter int unsigned EP_BYTES = 8,
  parameter int unsigned CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          commit_fire,
  input  logic          txack,
  input  logic          wp_busy,
  output logic          fifocon_o,
  output logic          txini_o,
  output logic [CW-1:0] byct_o,
  output logic          wr_ready_o,
  output logic          wr_fire_o
);
  localparam logic [CW-1:0] FULL = CW'(EP_BYTES);

  logic          fifocon_q, txini_q;
  logic [CW-1:0] byct_q;

  assign wr_ready_o = fifocon_q && (byct_q < FULL);
  assign wr_fire_o  = wr_valid && wr_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifocon_q <= 1'b1;
      txini_q   <= 1'b1;
      byct_q    <= '0;
    end else if (!fifocon_q) begin
      if (!wp_busy) begin
        fifocon_q <= 1'b1;
        txini_q   <= 1'b1;
        byct_q    <= '0;
      end
    end else if (commit_fire) begin
      fifocon_q <= 1'b0;
      txini_q   <= 1'b0;
      byct_q    <= '0;
    end else begin
      if (wr_fire_o) byct_q <= byct_q + CW'(1);
      if (txack) txini_q <= 1'b0;
    end
  end

  assign fifocon_o = fifocon_q;
  assign txini_o   = txini_q;
  assign byct_o    = byct_q;
endmodule

// File: rtl/iep_store.sv
`timescale 1ns/1ps
// Byte storage and per-bank packet lengths.
module iep_store
  import iep_pkg::*;
#(
  parameter int unsigned EP_BYTES = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned AW       = 3,
  parameter int unsigned CW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  bank_t             wbank,
  input  logic [AW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              len_we,
  input  logic [CW-1:0]     len_val,
  input  bank_t             rbank,
  input  logic [AW-1:0]     ridx,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     rlen
);
  logic [DATA_W-1:0] bank_rd  [IEP_BANKS];
  logic [CW-1:0]     bank_len [IEP_BANKS];

  for (genvar b = 0; b < IEP_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [EP_BYTES];
    logic [CW-1:0]     len_q;

    always_ff @(posedge clk) begin
      if (we && (wbank == bank_t'(b))) mem_q[widx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q <= '0;
      else if (len_we && (wbank == bank_t'(b))) len_q <= len_val;
    end

    assign bank_rd[b]  = mem_q[ridx];
    assign bank_len[b] = len_q;
  end

  assign rdata = bank_rd[rbank];
  assign rlen  = bank_len[rbank];
endmodule

// File: rtl/iep_pingpong.sv
`timescale 1ns/1ps
// Two-bank IN endpoint buffer between firmware and the transmit side.
module iep_pingpong
  import iep_pkg::*;
#(
  parameter  int unsigned EP_BYTES = 8,
  parameter  int unsigned DATA_W   = 8,
  localparam int unsigned AW       = $clog2(EP_BYTES),
  localparam int unsigned CW       = $clog2(EP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              txrdy_ack_i,
  input  logic              commit_i,
  input  logic              kill_i,
  input  logic              irq_en_i,
  output logic              txrdy_o,
  output logic              fifo_ctl_o,
  output logic              irq_o,
  output logic [CW-1:0]     byte_cnt_o,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic              pkt_bank_o,
  output logic [CW-1:0]     pkt_len_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  bank_t         wp, rp;
  occ_t          occ;
  logic          wp_busy, fifocon, txini, wr_fire;
  logic          ack_fire, commit_fire;
  logic [CW-1:0] byct, commit_len;

  assign pkt_valid_o = (occ != 2'd0);
  assign ack_fire    = pkt_valid_o && pkt_ready_i;
  // Kill takes priority: a commit in the same cycle is dropped.
  assign commit_fire = commit_i && fifocon && !kill_i;
  assign commit_len  = byct + CW'(wr_fire);

  iep_ring ring_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_fire    (ack_fire),
    .commit_fire (commit_fire),
    .kill_req    (kill_i),
    .fw_hold     (fifocon),
    .wp_o        (wp),
    .rp_o        (rp),
    .occ_o       (occ),
    .wp_busy_o   (wp_busy)
  );

  iep_fw_side #(.EP_BYTES(EP_BYTES), .CW(CW)) fw_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid_i),
    .commit_fire (commit_fire),
    .txack       (txrdy_ack_i),
    .wp_busy     (wp_busy),
    .fifocon_o   (fifocon),
    .txini_o     (txini),
    .byct_o      (byct),
    .wr_ready_o  (wr_ready_o),
    .wr_fire_o   (wr_fire)
  );

  iep_store #(.EP_BYTES(EP_BYTES), .DATA_W(DATA_W), .AW(AW), .CW(CW)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_fire),
    .wbank   (wp),
    .widx    (byct[AW-1:0]),
    .wdata   (wr_data_i),
    .len_we  (commit_fire),
    .len_val (commit_len),
    .rbank   (rp),
    .ridx    (rd_addr_i),
    .rdata   (rd_data_o),
    .rlen    (pkt_len_o)
  );

  assign txrdy_o    = txini;
  assign fifo_ctl_o = fifocon;
  assign byte_cnt_o = byct;
  assign irq_o      = txini && irq_en_i;
  assign pkt_bank_o = rp[0];
endmodule

// File: rtl/iep_pingpong_chk.sv
`timescale 1ns/1ps
module iep_pingpong_chk #(
  parameter int unsigned EP_BYTES = 8,
  parameter int unsigned CW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid_i,
  input logic          wr_ready_o,
  input logic          txrdy_ack_i,
  input logic          commit_i,
  input logic          kill_i,
  input logic          irq_en_i,
  input logic          txrdy_o,
  input logic          fifo_ctl_o,
  input logic          irq_o,
  input logic [CW-1:0] byte_cnt_o,
  input logic          pkt_valid_o,
  input logic          pkt_ready_i,
  input logic          pkt_bank_o,
  input logic [CW-1:0] pkt_len_o
);
  localparam logic [CW-1:0] FULL = CW'(EP_BYTES);

  AST_IRQ_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txrdy_o) && irq_en_i |-> irq_o); // R2

  AST_TXACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ctl_o && txrdy_ack_i |=> !txrdy_o); // R3

  AST_WRITE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i && wr_ready_o && !commit_i |=> byte_cnt_o == $past(byte_cnt_o) + CW'(1)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt_o == FULL) |-> !wr_ready_o); // R5

  AST_COMMIT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ctl_o && commit_i && !kill_i |=> !fifo_ctl_o && !txrdy_o && (byte_cnt_o == '0)); // R6

  AST_PKT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i && !kill_i |=> pkt_valid_o && $stable(pkt_bank_o) && $stable(pkt_len_o)); // R8

  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i && !pkt_valid_o |=> !pkt_valid_o); // R9
endmodule

bind iep_pingpong iep_pingpong_chk #(.EP_BYTES(EP_BYTES), .CW(CW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .txrdy_ack_i (txrdy_ack_i),
  .commit_i    (commit_i),
  .kill_i      (kill_i),
  .irq_en_i    (irq_en_i),
  .txrdy_o     (txrdy_o),
  .fifo_ctl_o  (fifo_ctl_o),
  .irq_o       (irq_o),
  .byte_cnt_o  (byte_cnt_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_bank_o  (pkt_bank_o),
  .pkt_len_o   (pkt_len_o)
);

// File: tb/iep_pingpong_tb_top.sv
`timescale 1ns/1ps
module iep_pingpong_tb_top;
  localparam int EP = 8;
  localparam int AW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid_i = 1'b0;
  logic [7:0]    wr_data_i = '0;
  logic          wr_ready_o;
  logic          txrdy_ack_i = 1'b0;
  logic          commit_i = 1'b0;
  logic          kill_i = 1'b0;
  logic          irq_en_i = 1'b0;
  logic          txrdy_o, fifo_ctl_o, irq_o;
  logic [CW-1:0] byte_cnt_o;
  logic          pkt_valid_o;
  logic          pkt_ready_i = 1'b0;
  logic          pkt_bank_o;
  logic [CW-1:0] pkt_len_o;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    rd_data_o;

  always #2.5 clk = ~clk;

  iep_pingpong #(.EP_BYTES(EP), .DATA_W(8)) dut_i (.*);

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // Reference model state
  int m_fc, m_ti, m_bc, m_wp;
  int q[$];
  int m_mem [2][EP];
  int m_len [2];

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s got %0d exp %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    check("R3", "txrdy_o", int'(txrdy_o), m_ti);
    check("R7", "fifo_ctl_o", int'(fifo_ctl_o), m_fc);
    check("R2", "irq_o", int'(irq_o), m_ti & int'(irq_en_i));
    check("R4", "byte_cnt_o", int'(byte_cnt_o), m_bc);
    check("R5", "wr_ready_o", int'(wr_ready_o), (m_fc == 1 && m_bc < EP) ? 1 : 0);
    check("R8", "pkt_valid_o", int'(pkt_valid_o), (q.size() > 0) ? 1 : 0);
    if (q.size() > 0) begin
      check("R8", "pkt_bank_o", int'(pkt_bank_o), q[0]);
      check("R6", "pkt_len_o", int'(pkt_len_o), m_len[q[0]]);
      if (int'(rd_addr_i) < m_len[q[0]])
        check("R8", "rd_data_o", int'(rd_data_o), m_mem[q[0]][int'(rd_addr_i)]);
    end
  endtask

  task automatic model_edge();
    int  fc0 = m_fc;
    bit  wp_q = 0;
    bit  wf, cf;
    foreach (q[i]) if (q[i] == m_wp) wp_q = 1;
    wf = wr_valid_i && m_fc == 1 && m_bc < EP;
    cf = commit_i && m_fc == 1 && !kill_i;
    if (wf) m_mem[m_wp][m_bc] = int'(wr_data_i);
    if (pkt_ready_i && q.size() > 0) void'(q.pop_front());
    if (kill_i && q.size() > 0) begin
      int b = q.pop_back();
      if (fc0 == 0) m_wp = b;
    end
    if (fc0 == 0) begin
      if (!wp_q) begin m_fc = 1; m_ti = 1; m_bc = 0; end
    end else if (cf) begin
      m_len[m_wp] = m_bc + (wf ? 1 : 0);
      q.push_back(m_wp);
      m_wp = 1 - m_wp;
      m_fc = 0; m_ti = 0; m_bc = 0;
    end else begin
      if (wf) m_bc++;
      if (txrdy_ack_i) m_ti = 0;
    end
  endtask

  // Inputs are set at a falling edge; outputs are checked 1 ns later.
  task automatic step();
    #1;
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    commit_i = 0; kill_i = 0; txrdy_ack_i = 0;
  endtask

  task automatic write_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_valid_i = 1; wr_data_i = 8'(base + i);
      step();
    end
    wr_valid_i = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    m_fc = 1; m_ti = 1; m_bc = 0; m_wp = 0;
    m_len[0] = 0; m_len[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "txrdy_o", int'(txrdy_o), 1);
    check("R1", "fifo_ctl_o", int'(fifo_ctl_o), 1);
    check("R1", "byte_cnt_o", int'(byte_cnt_o), 0);
    check("R1", "pkt_valid_o", int'(pkt_valid_o), 0);
    @(negedge clk);

    // R2/R3: enable irq, acknowledge flag
    irq_en_i = 1; step();
    txrdy_ack_i = 1; step();
    check("R3", "txrdy after ack", int'(txrdy_o), 0);
    check("R3", "fifo_ctl after ack", int'(fifo_ctl_o), 1);

    // R4: three bytes, R6: commit, R7: other bank free -> refill after one cycle
    write_bytes(3, 8'h10);
    commit_i = 1; step();
    check("R6", "fifo_ctl after commit", int'(fifo_ctl_o), 0);
    step();
    check("R7", "fifo_ctl refilled", int'(fifo_ctl_o), 1);
    check("R8", "pkt_len first", int'(pkt_len_o), 3);

    // R5: fill bank 1 then attempt extra writes
    write_bytes(EP, 8'h40);
    check("R5", "wr_ready when full", int'(wr_ready_o), 0);
    write_bytes(2, 8'hE0);
    check("R5", "count unchanged", int'(byte_cnt_o), EP);
    commit_i = 1; step();
    repeat (3) step();
    check("R7", "waits while both queued", int'(fifo_ctl_o), 0);
    for (int a = 0; a < 3; a++) begin rd_addr_i = AW'(a); step(); end
    pkt_ready_i = 1; step(); pkt_ready_i = 0;
    step();
    check("R7", "refill after handshake", int'(fifo_ctl_o), 1);

    // R6 zero-length commit while bank 1 is still queued
    commit_i = 1; step();
    step();
    pkt_ready_i = 1; step(); pkt_ready_i = 0;
    check("R6", "zero length packet", int'(pkt_len_o), 0);
    pkt_ready_i = 1; step(); pkt_ready_i = 0;
    step();

    // R9: kill with nothing queued
    kill_i = 1; step();
    check("R9", "kill idle", int'(pkt_valid_o), 0);
    // R9: stack both banks, kill last
    write_bytes(2, 8'h20); commit_i = 1; step(); step();
    write_bytes(5, 8'h30); commit_i = 1; step();
    kill_i = 1; step();
    check("R9", "one left after kill", int'(pkt_len_o), 2);
    step();
    check("R9", "firmware gets killed bank", int'(fifo_ctl_o), 1);
    // R9: kill with commit in same cycle
    write_bytes(4, 8'h50);
    commit_i = 1; kill_i = 1; step();
    check("R9", "commit dropped by kill", int'(fifo_ctl_o), 1);
    // R9: kill colliding with the handshake that empties the queue
    pkt_ready_i = 1; kill_i = 1; step(); pkt_ready_i = 0;
    check("R9", "queue empty", int'(pkt_valid_o), 0);
    commit_i = 1; step(); step();
    write_bytes(1, 8'h77); commit_i = 1; step();
    pkt_ready_i = 1; kill_i = 1; step(); pkt_ready_i = 0;
    step(); step();

    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      wr_valid_i  = ($urandom_range(0, 9) < 6);
      wr_data_i   = 8'($urandom);
      commit_i    = ($urandom_range(0, 9) == 0);
      kill_i      = ($urandom_range(0, 24) == 0);
      txrdy_ack_i = ($urandom_range(0, 4) == 0);
      pkt_ready_i = ($urandom_range(0, 9) < 3);
      irq_en_i    = ($urandom_range(0, 7) != 0);
      rd_addr_i   = AW'($urandom);
      step();
    end
    wr_valid_i = 0; pkt_ready_i = 0;
    step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule